// File: doc/BRIEF.md
# Dual-Bank Interrupt Controller

This block collects 32 interrupt lines from peripherals and presents them to a processor as two request outputs. One is an ordinary interrupt request and the other is a fast interrupt request. Each output is served by its own bank of registers. Software picks, per line and per bank, whether the line is level or edge sensitive and which polarity counts as active. It also picks whether the line may reach that bank's output.

Lines enter through a two-flop synchronizer. A level-sensitive line is pending for exactly as long as its input sits at the active level. An edge-sensitive line is caught in a sticky latch on its active transition. The latch holds until software writes a one to that line's bit in the bank's acknowledge register. An interrupt handler reads a bank's status word and services its set bits. It repeats this until the word reads zero.

Registers are reached over a plain 32-bit bus with a byte address, a write strobe and a combinational read path. The register-file layout below is part of the software contract.

Top module: `dualbank_intc`

## Requirements
- R1: After reset every enable, trigger-select and invert register of both banks reads 0, all edge latches are empty, and both `irq_o` and `fiq_o` are low.
- R2: Byte offsets within a bank are: 0x00 synchronized raw lines (read only), 0x04 enable, 0x08 acknowledge (write only, reads 0), 0x0C trigger select, 0x10 invert, 0x14 masked status (read only). The fast bank repeats this layout at offset 0x20. Enable, trigger select and invert read back what was written. Any other offset reads 0, and writes to it change nothing.
- R3: A status bit is 1 exactly when its line is pending and its enable bit is 1. With every enable bit at 0, both outputs are low.
- R4: With trigger select bit 0 (level), invert 0 makes high active and invert 1 makes low active. The line is pending only while its input is active. Writing 1 to its acknowledge bit does not change its status.
- R5: With trigger select bit 1 (edge), invert 0 catches rising edges and invert 1 catches falling edges. A caught edge stays pending after the input returns to idle.
- R6: Writing 1 to an acknowledge bit empties that line's edge latch, so its status reads 0 on the next access. Acknowledge bits written as 0 leave their latches untouched.
- R7: If an active edge is detected in the same clock cycle as an acknowledge of that line, the latch stays set.
- R8: `irq_o` is the OR of the normal bank's status bits and `fiq_o` is the OR of the fast bank's status bits. Configuration and acknowledges in one bank do not affect the other.
- R9: Changing an invert bit while the line's input is steady does not catch an edge.
- R10: A level change on an input reaches the status word and outputs after two rising clock edges. A caught edge reaches them after three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_lines | input | 32 | Asynchronous interrupt inputs, one bit per line |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The hardest case to reach from the ports is a new active edge that is detected in the very cycle an acknowledge for the same line is written. The edge must be timed through the synchronizer so that it lands exactly on the write. The stimulus first fills the latch and returns the line to idle. It then raises the line on a falling clock edge and waits two full cycles. It drives the acknowledge write so that it is sampled on the third rising edge, the edge on which the latch would load. The latch must then read as still set. Exact-cycle checks of the two- and three-edge latencies keep that timing honest, and so does a separate invert flip on a steady line, which must not be taken for an edge.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int unsigned LINES  = 32;
    localparam int unsigned NBANKS = 2;
    localparam int unsigned ADDR_W = 6;

    typedef enum logic [2:0] {
        REG_SRC  = 3'd0,
        REG_EN   = 3'd1,
        REG_ACK  = 3'd2,
        REG_TRIG = 3'd3,
        REG_INV  = 3'd4,
        REG_PEND = 3'd5,
        REG_NONE = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int unsigned W = intc_pkg::LINES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] old;
        logic [1:0]   warm;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = async_i;
        st_d.s2   = st_q.s1;
        st_d.old  = st_q.s2;
        if (st_q.warm != 2'd3) st_d.warm = st_q.warm + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
    assign prev_o = st_q.old;

    assert_sync_two_stage_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.warm >= 2'd2) |-> (sync_o == $past(async_i, 2)));
endmodule

// File: rtl/intc_decode.sv
module intc_decode #(
    parameter int unsigned AW = intc_pkg::ADDR_W
) (
    input  logic [AW-1:0]       addr_i,
    output logic                bank_o,
    output intc_pkg::reg_sel_e  sel_o
);
    import intc_pkg::*;
    localparam int unsigned BANK_BIT = AW - 1;

    logic [2:0] word;

    always_comb begin
        word   = addr_i[4:2];
        bank_o = addr_i[BANK_BIT];
        if (addr_i[1:0] != 2'b00 || word > 3'd5) sel_o = REG_NONE;
        else                                      sel_o = reg_sel_e'(word);
    end
endmodule

// File: rtl/intc_bank.sv
module intc_bank #(
    parameter int unsigned W = intc_pkg::LINES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [W-1:0]       sync_i,
    input  logic [W-1:0]       prev_i,
    input  logic               wr_i,
    input  intc_pkg::reg_sel_e sel_i,
    input  logic [W-1:0]       wdata_i,
    output logic [W-1:0]       en_o,
    output logic [W-1:0]       trig_o,
    output logic [W-1:0]       inv_o,
    output logic [W-1:0]       status_o,
    output logic               req_o
);
    import intc_pkg::*;

    typedef struct packed {
        logic [W-1:0] en;
        logic [W-1:0] trig;
        logic [W-1:0] inv;
        logic [W-1:0] lat;
    } bank_t;

    bank_t bk_d, bk_q;
    logic [W-1:0] act_now, act_old, rise, ack, pending;

    always_comb begin
        act_now = sync_i ^ bk_q.inv;
        act_old = prev_i ^ bk_q.inv;
        rise    = act_now & ~act_old;
        ack     = (wr_i && sel_i == REG_ACK) ? wdata_i : '0;

        bk_d = bk_q;
        if (wr_i && sel_i == REG_EN)   bk_d.en   = wdata_i;
        if (wr_i && sel_i == REG_TRIG) bk_d.trig = wdata_i;
        if (wr_i && sel_i == REG_INV)  bk_d.inv  = wdata_i;
        bk_d.lat = bk_d.trig & ((bk_q.lat & ~ack) | rise);

        pending  = (bk_q.trig & bk_q.lat) | (~bk_q.trig & act_now);
        status_o = pending & bk_q.en;
        req_o    = |status_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign en_o   = bk_q.en;
    assign trig_o = bk_q.trig;
    assign inv_o  = bk_q.inv;

    assert_clear_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == REG_ACK) |=> ((bk_q.lat & $past(wdata_i & ~rise)) == '0));

    assert_edge_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(rise & bk_q.trig)) && !(wr_i && sel_i == REG_TRIG))
        |=> ((bk_q.lat & $past(rise & bk_q.trig)) == $past(rise & bk_q.trig)));

    assert_quiet_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bk_q.en == '0) |-> !req_o);

    assert_level_no_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((bk_q.lat & ~bk_q.trig) == '0));
endmodule

// File: rtl/dualbank_intc.sv
module dualbank_intc #(
    parameter int unsigned W  = intc_pkg::LINES,
    parameter int unsigned AW = intc_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic [W-1:0]  irq_lines,
    output logic          irq_o,
    output logic          fiq_o
);
    import intc_pkg::*;
    localparam int unsigned NB = NBANKS;

    logic [W-1:0] sync_v, prev_v;
    logic         dec_bank;
    reg_sel_e     dec_sel;

    logic [W-1:0] en_a   [NB];
    logic [W-1:0] trig_a [NB];
    logic [W-1:0] inv_a  [NB];
    logic [W-1:0] stat_a [NB];
    logic [NB-1:0] req_v;

    intc_sync #(.W(W)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(irq_lines),
        .sync_o(sync_v), .prev_o(prev_v)
    );

    intc_decode #(.AW(AW)) u_dec (
        .addr_i(bus_addr), .bank_o(dec_bank), .sel_o(dec_sel)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        intc_bank #(.W(W)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .sync_i(sync_v), .prev_i(prev_v),
            .wr_i(bus_wr && (dec_bank == b[0])),
            .sel_i(dec_sel), .wdata_i(bus_wdata[W-1:0]),
            .en_o(en_a[b]), .trig_o(trig_a[b]), .inv_o(inv_a[b]),
            .status_o(stat_a[b]), .req_o(req_v[b])
        );
    end

    always_comb begin
        bus_rdata = '0;
        case (dec_sel)
            REG_SRC:  bus_rdata[W-1:0] = sync_v;
            REG_EN:   bus_rdata[W-1:0] = en_a[dec_bank];
            REG_TRIG: bus_rdata[W-1:0] = trig_a[dec_bank];
            REG_INV:  bus_rdata[W-1:0] = inv_a[dec_bank];
            REG_PEND: bus_rdata[W-1:0] = stat_a[dec_bank];
            default:  bus_rdata = '0;
        endcase
    end

    assign irq_o = req_v[0];
    assign fiq_o = req_v[1];

    assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_sel == REG_NONE || dec_sel == REG_ACK) |-> (bus_rdata == '0));

    assert_all_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_a[0] == '0 && en_a[1] == '0) |-> (!irq_o && !fiq_o));
endmodule

// File: tb/dualbank_intc_test.sv
module dualbank_intc_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] lines = '0;
    logic        irq_o, fiq_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    localparam logic [5:0] A_SRC = 6'h00, A_EN = 6'h04, A_ACK = 6'h08,
                           A_TRIG = 6'h0C, A_INV = 6'h10, A_PEND = 6'h14,
                           F = 6'h20;

    always #5 clk = ~clk;

    dualbank_intc uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lines(lines),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic cfg_clear();
        for (int b = 0; b < 2; b++) begin
            wr(A_EN | (b ? F : 6'h0), '0);
            wr(A_TRIG | (b ? F : 6'h0), '0);
            wr(A_INV | (b ? F : 6'h0), '0);
            wr(A_ACK | (b ? F : 6'h0), '1);
        end
        lines = '0;
        idle(4);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int b = 0; b < 2; b++) begin
            rd(A_EN | (b ? F : 6'h0), d);   chk("R1 enable", d, 0);
            rd(A_TRIG | (b ? F : 6'h0), d); chk("R1 trigger", d, 0);
            rd(A_INV | (b ? F : 6'h0), d);  chk("R1 invert", d, 0);
            rd(A_PEND | (b ? F : 6'h0), d); chk("R1 status", d, 0);
        end
        chk("R1 outputs", {30'd0, irq_o, fiq_o}, 0);
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        wr(A_EN, 32'hA5A5_0001);  wr(F | A_EN, 32'h0F0F_8000);
        wr(A_TRIG, 32'h1234_5678); wr(F | A_INV, 32'hDEAD_BEEF);
        rd(A_EN, d);       chk("R2 irq enable", d, 32'hA5A5_0001);
        rd(F | A_EN, d);   chk("R2 fiq enable", d, 32'h0F0F_8000);
        rd(A_TRIG, d);     chk("R2 irq trigger", d, 32'h1234_5678);
        rd(F | A_TRIG, d); chk("R2 fiq trigger", d, 0);
        rd(F | A_INV, d);  chk("R2 fiq invert", d, 32'hDEAD_BEEF);
        wr(6'h18, 32'hFFFF_FFFF);
        rd(6'h18, d);      chk("R2 unmapped", d, 0);
        rd(A_ACK, d);      chk("R2 ack reads zero", d, 0);
        rd(A_EN, d);       chk("R2 unmapped write ignored", d, 32'hA5A5_0001);
        cfg_clear();
        lines = 32'h1357_9BDF;
        idle(3);
        rd(A_SRC, d);      chk("R2 irq source", d, 32'h1357_9BDF);
        rd(F | A_SRC, d);  chk("R2 fiq source", d, 32'h1357_9BDF);
        cfg_clear();
    endtask

    task automatic t_level();
        logic [31:0] d;
        wr(A_EN, 32'h0000_0028);
        wr(A_INV, 32'h0000_0020);
        idle(3);
        rd(A_PEND, d); chk("R4 active-low idle input pending", d, 32'h20);
        lines[5] = 1;
        idle(3);
        rd(A_PEND, d); chk("R4 active-low released", d, 0);
        lines[7] = 1;
        lines[3] = 1;
        @(negedge clk); chk("R10 level after one edge", irq_o, 0);
        @(negedge clk); chk("R10 level after two edges", irq_o, 1);
        rd(A_PEND, d); chk("R3 masked line excluded", d, 32'h08);
        wr(A_ACK, 32'h08);
        rd(A_PEND, d); chk("R4 ack ignored in level", d, 32'h08);
        lines[3] = 0;
        idle(3);
        chk("R4 level not latched", irq_o, 0);
        cfg_clear();
    endtask

    task automatic t_edge();
        logic [31:0] d;
        wr(A_TRIG, 32'h0000_1400);
        wr(A_INV, 32'h0000_1000);
        wr(A_EN, 32'h0000_1400);
        lines[12] = 1;
        idle(4);
        chk("R5 idle falling line quiet", irq_o, 0);
        lines[10] = 1;
        @(negedge clk); @(negedge clk);
        chk("R10 edge after two edges", irq_o, 0);
        @(negedge clk);
        chk("R10 edge after three edges", irq_o, 1);
        lines[10] = 0;
        idle(3);
        rd(A_PEND, d); chk("R5 rising edge latched", d, 32'h400);
        wr(A_ACK, 32'hFFFF_FBFF);
        rd(A_PEND, d); chk("R6 zero bits no effect", d, 32'h400);
        wr(A_ACK, 32'h0000_0400);
        rd(A_PEND, d); chk("R6 write-one clears", d, 0);
        lines[12] = 0;
        idle(4);
        lines[12] = 1;
        idle(3);
        rd(A_PEND, d); chk("R5 falling edge latched", d, 32'h1000);
        cfg_clear();
    endtask

    task automatic t_race();
        logic [31:0] d;
        wr(A_TRIG, 32'h8000);
        wr(A_EN, 32'h8000);
        lines[15] = 1;
        idle(4);
        lines[15] = 0;
        idle(4);
        rd(A_PEND, d); chk("R7 latch primed", d, 32'h8000);
        lines[15] = 1;
        @(negedge clk);
        @(negedge clk);
        bus_addr = A_ACK; bus_wdata = 32'h8000; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
        rd(A_PEND, d); chk("R7 new edge beats ack", d, 32'h8000);
        wr(A_ACK, 32'h8000);
        rd(A_PEND, d); chk("R7 later ack clears", d, 0);
        cfg_clear();
    endtask

    task automatic t_polarity();
        logic [31:0] d;
        wr(A_TRIG, 32'h0010_0000);
        wr(A_EN, 32'h0010_0000);
        idle(3);
        wr(A_INV, 32'h0010_0000);
        idle(4);
        rd(A_PEND, d); chk("R9 invert flip no edge", d, 0);
        wr(A_INV, 32'h0);
        idle(4);
        rd(A_PEND, d); chk("R9 invert restore no edge", d, 0);
        cfg_clear();
    endtask

    task automatic t_banks();
        logic [31:0] d;
        wr(F | A_EN, 32'h0200_0000);
        lines[25] = 1;
        idle(3);
        chk("R8 fiq only", {30'd0, irq_o, fiq_o}, 32'h1);
        wr(A_EN, 32'h0200_0000);
        chk("R8 both banks", {30'd0, irq_o, fiq_o}, 32'h3);
        wr(A_EN, 0); wr(F | A_EN, 0);
        chk("R3 all masks zero", {30'd0, irq_o, fiq_o}, 0);
        wr(A_TRIG, 32'h0400_0000); wr(F | A_TRIG, 32'h0400_0000);
        wr(A_EN, 32'h0400_0000);   wr(F | A_EN, 32'h0400_0000);
        lines[26] = 1;
        idle(4);
        wr(F | A_ACK, 32'h0400_0000);
        chk("R8 fiq acked", fiq_o, 0);
        rd(A_PEND, d); chk("R8 irq latch independent", d, 32'h0400_0000);
        chk("R8 irq still asserted", irq_o, 1);
        cfg_clear();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1;
        idle(1);
        t_reset();
        t_regmap();
        t_level();
        t_edge();
        t_race();
        t_polarity();
        t_banks();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule